// File: doc/BRIEF.md
# Instruction decoder for a 32-bit load/store RISC subset

This block is purely combinational. It takes one fixed-width 32-bit instruction word and splits it into its bit fields. It names the encoding format of the word and drives the control lines that a single-issue datapath needs to carry out the instruction. It covers:

- register-to-register arithmetic, logic, compare and shift operations;
- immediate arithmetic and logic operations;
- word load and word store;
- equal and not-equal branches;
- absolute jumps, register jumps and the linking variants of both.

Any opcode or function code outside that set raises an illegal flag. It also holds every state-changing enable low, so a bad word can never write a register or memory.

The decoder sits between instruction fetch and the register file and ALU. The datapath uses its outputs as follows:

- The register-file read ports take the two source indices.
- The write port takes the resolved destination index and the write enable.
- The ALU takes the operation code, the operand-B select and the extended immediate.
- The memory and next-PC logic take the remaining strobes.

Top module: `insn_decoder`

## Requirements
- R1: The fields come out at fixed positions of `insn`: `opcode` = [31:26], `rs_idx` = [25:21], `rt_idx` = [20:16], `rd_idx` = [15:11], `shamt` = [10:6], `funct` = [5:0], `imm16` = [15:0], `target` = [25:0].
- R2: `fmt` is 0 for opcode 0x00 (register format), 2 for opcodes 0x02 and 0x03 (jump format), 1 for any other supported opcode (immediate format), and 3 for an unsupported opcode.
- R3: `wr_idx` is `rd_idx` for register-format instructions that write, including jalr. It is `rt_idx` for immediate ALU operations and for lw, and 31 for jal. Whenever `reg_we` is 0, `wr_idx` is 0.
- R4: `imm_ext` is `imm16` sign-extended for addi (0x08), addiu (0x09), slti (0x0A), sltiu (0x0B), lw (0x23), sw (0x2B), beq (0x04), bne (0x05) and all non-immediate words, with `imm_sext` = 1. It is zero-extended for andi (0x0C), ori (0x0D) and xori (0x0E), with `imm_sext` = 0.
- R5: For lui (0x0F), `imm_ext` = {`imm16`, 16'h0000}, `imm_sext` = 0, `alu_op` = 11, and the result is written to `rt_idx`.
- R6: lw asserts `mem_rd`, writes `rt_idx`, and uses `alu_op` 0 with an immediate operand. sw asserts `mem_wr`, does not write a register, and uses `alu_op` 0 with an immediate operand. No word asserts both strobes.
- R7: `alu_op` codes are add 0, sub 1, and 2, or 3, xor 4, nor 5, slt 6, sltu 7, shift-left 8, shift-right-logical 9, shift-right-arithmetic 10, load-upper 11, addu 12, subu 13, none 15. Register format maps funct 0x20–0x27, 0x2A and 0x2B onto these codes, and addi/addiu/slti/sltiu/andi/ori/xori onto the matching codes.
- R8: beq asserts `br_eq` and bne asserts `br_ne`. Both use `alu_op` 1 with a register operand and write no register.
- R9: j and jal assert `jmp_abs`; jr (funct 0x08) and jalr (funct 0x09) assert `jmp_reg`. jal and jalr additionally assert `link` and `reg_we`, while j and jr write no register. All four use `alu_op` 15.
- R10: sll/srl/sra (funct 0x00/0x02/0x03) take the shift amount from `shamt` (`shift_var` = 0). sllv/srlv/srav (funct 0x04/0x06/0x07) take it from the low five bits of rs (`shift_var` = 1).
- R11: `alu_imm` is 1 exactly for the immediate ALU operations, lui, lw and sw.
- R12: Any unlisted opcode, or any unlisted funct under opcode 0x00, sets `illegal`. It forces `reg_we`, `mem_rd`, `mem_wr`, `br_eq`, `br_ne`, `jmp_abs`, `jmp_reg` and `link` low and `alu_op` to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word to decode |
| opcode | output | 6 | Major operation field |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source / immediate destination index |
| rd_idx | output | 5 | Register-format destination index |
| shamt | output | 5 | Constant shift amount |
| funct | output | 6 | Register-format function field |
| imm16 | output | 16 | Raw immediate |
| target | output | 26 | Raw jump target |
| fmt | output | 2 | Format code (R=0, I=1, J=2, bad=3) |
| wr_idx | output | 5 | Resolved destination register index |
| reg_we | output | 1 | Register write enable |
| alu_op | output | 4 | ALU operation code |
| alu_imm | output | 1 | ALU operand B is the extended immediate |
| imm_sext | output | 1 | Immediate was sign-extended |
| imm_ext | output | 32 | Extended or placed immediate |
| mem_rd | output | 1 | Data memory word read |
| mem_wr | output | 1 | Data memory word write |
| br_eq | output | 1 | Branch if operands equal |
| br_ne | output | 1 | Branch if operands differ |
| jmp_abs | output | 1 | Jump to absolute target |
| jmp_reg | output | 1 | Jump to address in rs |
| link | output | 1 | Save return address |
| shift_var | output | 1 | Shift amount comes from rs |
| illegal | output | 1 | Unsupported encoding |

## Verification
Two functions meet in one word for jal and jalr: a control transfer and a register write at the same time. For jal, the write must also be steered away from every instruction field onto register 31. The bench drives both linking jumps with field values that differ from 31. It checks that `jmp_abs` or `jmp_reg`, `link`, `reg_we` and the resolved `wr_idx` all hold together. It then checks that the non-linking jumps beside them raise the jump without the write.

// File: rtl/insn_decoder_pkg.sv
package insn_decoder_pkg;

  localparam int XLEN     = 32;
  localparam int OP_W     = 6;
  localparam int REG_W    = 5;
  localparam int FN_W     = 6;
  localparam int IMM_W    = 16;
  localparam int TGT_W    = 26;
  localparam int OP_LSB   = XLEN - OP_W;
  localparam int RS_LSB   = OP_LSB - REG_W;
  localparam int RT_LSB   = RS_LSB - REG_W;
  localparam int RD_LSB   = RT_LSB - REG_W;
  localparam int SH_LSB   = RD_LSB - REG_W;

  // major opcodes
  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_J     = 6'h02;
  localparam logic [OP_W-1:0] OPC_JAL   = 6'h03;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'h05;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OP_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OP_W-1:0] OPC_SLTIU = 6'h0B;
  localparam logic [OP_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OP_W-1:0] OPC_LUI   = 6'h0F;
  localparam logic [OP_W-1:0] OPC_LW    = 6'h23;
  localparam logic [OP_W-1:0] OPC_SW    = 6'h2B;

  // register-format function codes
  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
  localparam logic [FN_W-1:0] FN_JR   = 6'h08;
  localparam logic [FN_W-1:0] FN_JALR = 6'h09;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,  ALU_SUB  = 4'd1,  ALU_AND  = 4'd2,  ALU_OR   = 4'd3,
    ALU_XOR  = 4'd4,  ALU_NOR  = 4'd5,  ALU_SLT  = 4'd6,  ALU_SLTU = 4'd7,
    ALU_SLL  = 4'd8,  ALU_SRL  = 4'd9,  ALU_SRA  = 4'd10, ALU_LUI  = 4'd11,
    ALU_ADDU = 4'd12, ALU_SUBU = 4'd13, ALU_NONE = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {FMT_R = 2'd0, FMT_I = 2'd1, FMT_J = 2'd2, FMT_BAD = 2'd3} fmt_e;
  typedef enum logic [1:0] {EXT_SIGN = 2'd0, EXT_ZERO = 2'd1, EXT_UPPER = 2'd2} ext_e;
  typedef enum logic [1:0] {DST_NONE = 2'd0, DST_RD = 2'd1, DST_RT = 2'd2, DST_LINK = 2'd3} dst_e;

  typedef struct packed {
    fmt_e    fmt;
    dst_e    dst;
    alu_op_e alu;
    logic    src_imm;
    ext_e    ext;
    logic    mem_rd;
    logic    mem_wr;
    logic    br_eq;
    logic    br_ne;
    logic    jmp_abs;
    logic    jmp_reg;
    logic    link;
    logic    shift_var;
    logic    illegal;
  } ctrl_t;

  function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] raw, input ext_e mode);
    logic [XLEN-1:0] r;
    case (mode)
      EXT_ZERO:  r = {{(XLEN-IMM_W){1'b0}}, raw};
      EXT_UPPER: r = {raw, {(XLEN-IMM_W){1'b0}}};
      default:   r = {{(XLEN-IMM_W){raw[IMM_W-1]}}, raw};
    endcase
    return r;
  endfunction

  function automatic ctrl_t ctrl_idle();
    ctrl_t c;
    c.fmt = FMT_R;   c.dst = DST_NONE; c.alu = ALU_NONE; c.src_imm = 1'b0;
    c.ext = EXT_SIGN; c.mem_rd = 1'b0; c.mem_wr = 1'b0; c.br_eq = 1'b0;
    c.br_ne = 1'b0;  c.jmp_abs = 1'b0; c.jmp_reg = 1'b0; c.link = 1'b0;
    c.shift_var = 1'b0; c.illegal = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/insn_fields.sv
module insn_fields
  import insn_decoder_pkg::*;
(
  input  logic [XLEN-1:0]  word,
  output logic [OP_W-1:0]  f_op,
  output logic [REG_W-1:0] f_rs,
  output logic [REG_W-1:0] f_rt,
  output logic [REG_W-1:0] f_rd,
  output logic [REG_W-1:0] f_sh,
  output logic [FN_W-1:0]  f_fn,
  output logic [IMM_W-1:0] f_imm,
  output logic [TGT_W-1:0] f_tgt
);
  assign f_op  = word[OP_LSB +: OP_W];
  assign f_rs  = word[RS_LSB +: REG_W];
  assign f_rt  = word[RT_LSB +: REG_W];
  assign f_rd  = word[RD_LSB +: REG_W];
  assign f_sh  = word[SH_LSB +: REG_W];
  assign f_fn  = word[0 +: FN_W];
  assign f_imm = word[0 +: IMM_W];
  assign f_tgt = word[0 +: TGT_W];
endmodule

// File: rtl/insn_ctrl.sv
module insn_ctrl
  import insn_decoder_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] fn,
  output ctrl_t           ctl
);
  ctrl_t reg_c;
  ctrl_t imm_c;

  // register-format decode
  always_comb begin
    reg_c     = ctrl_idle();
    reg_c.fmt = FMT_R;
    reg_c.dst = DST_RD;
    case (fn)
      FN_ADD:  reg_c.alu = ALU_ADD;
      FN_ADDU: reg_c.alu = ALU_ADDU;
      FN_SUB:  reg_c.alu = ALU_SUB;
      FN_SUBU: reg_c.alu = ALU_SUBU;
      FN_AND:  reg_c.alu = ALU_AND;
      FN_OR:   reg_c.alu = ALU_OR;
      FN_XOR:  reg_c.alu = ALU_XOR;
      FN_NOR:  reg_c.alu = ALU_NOR;
      FN_SLT:  reg_c.alu = ALU_SLT;
      FN_SLTU: reg_c.alu = ALU_SLTU;
      FN_SLL:  reg_c.alu = ALU_SLL;
      FN_SRL:  reg_c.alu = ALU_SRL;
      FN_SRA:  reg_c.alu = ALU_SRA;
      FN_SLLV: begin reg_c.alu = ALU_SLL; reg_c.shift_var = 1'b1; end
      FN_SRLV: begin reg_c.alu = ALU_SRL; reg_c.shift_var = 1'b1; end
      FN_SRAV: begin reg_c.alu = ALU_SRA; reg_c.shift_var = 1'b1; end
      FN_JR:   begin reg_c.dst = DST_NONE; reg_c.jmp_reg = 1'b1; end
      FN_JALR: begin reg_c.jmp_reg = 1'b1; reg_c.link = 1'b1; end
      default: begin reg_c.dst = DST_NONE; reg_c.illegal = 1'b1; end
    endcase
  end

  // immediate and jump format decode
  always_comb begin
    imm_c         = ctrl_idle();
    imm_c.fmt     = FMT_I;
    imm_c.dst     = DST_RT;
    imm_c.src_imm = 1'b1;
    case (op)
      OPC_ADDI:  imm_c.alu = ALU_ADD;
      OPC_ADDIU: imm_c.alu = ALU_ADDU;
      OPC_SLTI:  imm_c.alu = ALU_SLT;
      OPC_SLTIU: imm_c.alu = ALU_SLTU;
      OPC_ANDI:  begin imm_c.alu = ALU_AND; imm_c.ext = EXT_ZERO; end
      OPC_ORI:   begin imm_c.alu = ALU_OR;  imm_c.ext = EXT_ZERO; end
      OPC_XORI:  begin imm_c.alu = ALU_XOR; imm_c.ext = EXT_ZERO; end
      OPC_LUI:   begin imm_c.alu = ALU_LUI; imm_c.ext = EXT_UPPER; end
      OPC_LW:    begin imm_c.alu = ALU_ADD; imm_c.mem_rd = 1'b1; end
      OPC_SW:    begin imm_c.alu = ALU_ADD; imm_c.mem_wr = 1'b1; imm_c.dst = DST_NONE; end
      OPC_BEQ:   begin imm_c.alu = ALU_SUB; imm_c.br_eq = 1'b1; imm_c.dst = DST_NONE; imm_c.src_imm = 1'b0; end
      OPC_BNE:   begin imm_c.alu = ALU_SUB; imm_c.br_ne = 1'b1; imm_c.dst = DST_NONE; imm_c.src_imm = 1'b0; end
      OPC_J: begin
        imm_c.fmt = FMT_J; imm_c.dst = DST_NONE; imm_c.src_imm = 1'b0; imm_c.jmp_abs = 1'b1;
      end
      OPC_JAL: begin
        imm_c.fmt = FMT_J; imm_c.dst = DST_LINK; imm_c.src_imm = 1'b0;
        imm_c.jmp_abs = 1'b1; imm_c.link = 1'b1;
      end
      default: begin
        imm_c = ctrl_idle();
        imm_c.fmt = FMT_BAD;
        imm_c.illegal = 1'b1;
      end
    endcase
  end

  assign ctl = (op == OPC_REG) ? reg_c : imm_c;
endmodule

// File: rtl/insn_immgen.sv
module insn_immgen
  import insn_decoder_pkg::*;
(
  input  logic [IMM_W-1:0] raw,
  input  ext_e             mode,
  output logic [XLEN-1:0]  value,
  output logic             is_signed
);
  assign value     = widen_imm(raw, mode);
  assign is_signed = (mode == EXT_SIGN);
endmodule

// File: rtl/insn_dstsel.sv
module insn_dstsel
  import insn_decoder_pkg::*;
#(
  parameter int LINK_REG = 31
) (
  input  dst_e             sel,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rt,
  output logic [REG_W-1:0] idx,
  output logic             we
);
  localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);
  always_comb begin
    case (sel)
      DST_RD:   idx = rd;
      DST_RT:   idx = rt;
      DST_LINK: idx = LINK_IDX;
      default:  idx = '0;
    endcase
  end
  assign we = (sel != DST_NONE);
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_decoder_pkg::*;
#(
  parameter int LINK_REG = 31
) (
  input  logic [31:0] insn,
  output logic [5:0]  opcode,
  output logic [4:0]  rs_idx,
  output logic [4:0]  rt_idx,
  output logic [4:0]  rd_idx,
  output logic [4:0]  shamt,
  output logic [5:0]  funct,
  output logic [15:0] imm16,
  output logic [25:0] target,
  output logic [1:0]  fmt,
  output logic [4:0]  wr_idx,
  output logic        reg_we,
  output logic [3:0]  alu_op,
  output logic        alu_imm,
  output logic        imm_sext,
  output logic [31:0] imm_ext,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        br_eq,
  output logic        br_ne,
  output logic        jmp_abs,
  output logic        jmp_reg,
  output logic        link,
  output logic        shift_var,
  output logic        illegal
);
  ctrl_t ctl;

  insn_fields u_fields (
    .word(insn), .f_op(opcode), .f_rs(rs_idx), .f_rt(rt_idx), .f_rd(rd_idx),
    .f_sh(shamt), .f_fn(funct), .f_imm(imm16), .f_tgt(target)
  );

  insn_ctrl u_ctrl (.op(opcode), .fn(funct), .ctl(ctl));

  insn_immgen u_imm (.raw(imm16), .mode(ctl.ext), .value(imm_ext), .is_signed(imm_sext));

  insn_dstsel #(.LINK_REG(LINK_REG)) u_dst (
    .sel(ctl.dst), .rd(rd_idx), .rt(rt_idx), .idx(wr_idx), .we(reg_we)
  );

  assign fmt       = ctl.fmt;
  assign alu_op    = ctl.alu;
  assign alu_imm   = ctl.src_imm;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign br_eq     = ctl.br_eq;
  assign br_ne     = ctl.br_ne;
  assign jmp_abs   = ctl.jmp_abs;
  assign jmp_reg   = ctl.jmp_reg;
  assign link      = ctl.link;
  assign shift_var = ctl.shift_var;
  assign illegal   = ctl.illegal;
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk (
  input logic [5:0]  opcode,
  input logic [4:0]  rt_idx,
  input logic [4:0]  wr_idx,
  input logic        reg_we,
  input logic [3:0]  alu_op,
  input logic        imm_sext,
  input logic [31:0] imm_ext,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        br_eq,
  input logic        br_ne,
  input logic        jmp_abs,
  input logic        jmp_reg,
  input logic        link,
  input logic        illegal
);
  always_comb begin
    assert_illegal_quiet_R12: assert (!illegal || !(reg_we | mem_rd | mem_wr | br_eq | br_ne | jmp_abs | jmp_reg | link))
      else $error("illegal word left an enable high");
    assert_mem_excl_R6: assert (!(mem_rd && mem_wr))
      else $error("load and store strobes together");
    assert_link_writes_R9: assert (!link || (reg_we && (jmp_abs || jmp_reg)))
      else $error("link without write or jump");
    assert_nowrite_idx_R3: assert (reg_we || wr_idx == 5'd0)
      else $error("destination index without write");
    assert_zext_top_R4: assert (imm_sext || alu_op == 4'd11 || imm_ext[31:16] == 16'h0000)
      else $error("zero-extended immediate has upper bits");
    assert_upper_low_R5: assert (alu_op != 4'd11 || (imm_ext[15:0] == 16'h0000 && wr_idx == rt_idx))
      else $error("load-upper result malformed");
    assert_branch_nowrite_R8: assert (!(br_eq || br_ne) || (!reg_we && !jmp_abs && !jmp_reg))
      else $error("branch also writes or jumps");
    assert_store_nowrite_R6: assert (!(mem_wr && reg_we))
      else $error("store writes a register");
    assert_sw_op_R6: assert (!(opcode == 6'h2B) || mem_wr)
      else $error("store opcode without write strobe");
  end
endmodule

bind insn_decoder insn_decoder_chk u_chk (
  .opcode(opcode), .rt_idx(rt_idx), .wr_idx(wr_idx), .reg_we(reg_we), .alu_op(alu_op),
  .imm_sext(imm_sext), .imm_ext(imm_ext), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .br_eq(br_eq), .br_ne(br_ne), .jmp_abs(jmp_abs), .jmp_reg(jmp_reg),
  .link(link), .illegal(illegal)
);

// File: tb/test_insn_decoder.sv
module test_insn_decoder;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] insn;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs_idx, rt_idx, rd_idx, shamt, wr_idx;
  logic [15:0] imm16;
  logic [25:0] target;
  logic [1:0]  fmt;
  logic        reg_we, alu_imm, imm_sext, mem_rd, mem_wr, br_eq, br_ne;
  logic        jmp_abs, jmp_reg, link, shift_var, illegal;
  logic [3:0]  alu_op;
  logic [31:0] imm_ext;

  insn_decoder i_insn_decoder (
    .insn(insn), .opcode(opcode), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx),
    .shamt(shamt), .funct(funct), .imm16(imm16), .target(target), .fmt(fmt),
    .wr_idx(wr_idx), .reg_we(reg_we), .alu_op(alu_op), .alu_imm(alu_imm),
    .imm_sext(imm_sext), .imm_ext(imm_ext), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .br_eq(br_eq), .br_ne(br_ne), .jmp_abs(jmp_abs), .jmp_reg(jmp_reg),
    .link(link), .shift_var(shift_var), .illegal(illegal)
  );

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [31:0] rw(int rs, int rt, int rd, int sh, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] iw(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] jw(int op, int tgt);
    return {6'(op), 26'(tgt)};
  endfunction
  // fmt, we, widx, alu, aimm, mrd, mwr, beq, bne, jabs, jreg, lnk, svar, ill, sext
  function automatic logic [22:0] ex(int f, int we, int wi, int al, int ai, int mr, int mw,
                                     int be, int bn, int ja, int jr, int lk, int sv, int il, int se);
    return {2'(f), 1'(we), 5'(wi), 4'(al), 1'(ai), 1'(mr), 1'(mw), 1'(be), 1'(bn),
            1'(ja), 1'(jr), 1'(lk), 1'(sv), 1'(il), 1'(se)};
  endfunction

  localparam int NV = 34;
  localparam logic [86:0] VEC [NV] = '{
    {"R7  ", rw(11, 9, 10, 0, 'h20), ex(0,1,10, 0,0,0,0,0,0,0,0,0,0,0,1)},
    {"R7  ", rw(1, 2, 3, 0, 'h22),   ex(0,1, 3, 1,0,0,0,0,0,0,0,0,0,0,1)},
    {"R7  ", rw(4, 5, 6, 0, 'h21),   ex(0,1, 6,12,0,0,0,0,0,0,0,0,0,0,1)},
    {"R7  ", rw(4, 5, 7, 0, 'h23),   ex(0,1, 7,13,0,0,0,0,0,0,0,0,0,0,1)},
    {"R7  ", rw(4, 5, 8, 0, 'h24),   ex(0,1, 8, 2,0,0,0,0,0,0,0,0,0,0,1)},
    {"R7  ", rw(4, 5, 9, 0, 'h25),   ex(0,1, 9, 3,0,0,0,0,0,0,0,0,0,0,1)},
    {"R7  ", rw(4, 5,12, 0, 'h26),   ex(0,1,12, 4,0,0,0,0,0,0,0,0,0,0,1)},
    {"R7  ", rw(4, 5,13, 0, 'h27),   ex(0,1,13, 5,0,0,0,0,0,0,0,0,0,0,1)},
    {"R7  ", rw(4, 5,14, 0, 'h2A),   ex(0,1,14, 6,0,0,0,0,0,0,0,0,0,0,1)},
    {"R7  ", rw(4, 5,15, 0, 'h2B),   ex(0,1,15, 7,0,0,0,0,0,0,0,0,0,0,1)},
    {"R10 ", rw(0, 2, 2, 4, 'h00),   ex(0,1, 2, 8,0,0,0,0,0,0,0,0,0,0,1)},
    {"R10 ", rw(0, 3,17, 9, 'h02),   ex(0,1,17, 9,0,0,0,0,0,0,0,0,0,0,1)},
    {"R10 ", rw(0, 3,18,31, 'h03),   ex(0,1,18,10,0,0,0,0,0,0,0,0,0,0,1)},
    {"R10 ", rw(8, 2, 2, 0, 'h04),   ex(0,1, 2, 8,0,0,0,0,0,0,0,0,1,0,1)},
    {"R10 ", rw(8, 2,19, 0, 'h06),   ex(0,1,19, 9,0,0,0,0,0,0,0,0,1,0,1)},
    {"R10 ", rw(8, 2,20, 0, 'h07),   ex(0,1,20,10,0,0,0,0,0,0,0,0,1,0,1)},
    {"R9  ", rw(8, 0, 0, 0, 'h08),   ex(0,0, 0,15,0,0,0,0,0,0,1,0,0,0,1)},
    {"R9  ", rw(8, 0, 5, 0, 'h09),   ex(0,1, 5,15,0,0,0,0,0,0,1,1,0,0,1)},
    {"R12 ", rw(8, 9,10, 0, 'h01),   ex(0,0, 0,15,0,0,0,0,0,0,0,0,0,1,1)},
    {"R4  ", iw('h08,11, 9,'hFFFD),  ex(1,1, 9, 0,1,0,0,0,0,0,0,0,0,0,1)},
    {"R4  ", iw('h09, 1, 2,'h8000),  ex(1,1, 2,12,1,0,0,0,0,0,0,0,0,0,1)},
    {"R4  ", iw('h0A, 1, 3,'h000A),  ex(1,1, 3, 6,1,0,0,0,0,0,0,0,0,0,1)},
    {"R4  ", iw('h0B, 1, 4,'hF00F),  ex(1,1, 4, 7,1,0,0,0,0,0,0,0,0,0,1)},
    {"R4  ", iw('h0C, 1, 5,'h80FF),  ex(1,1, 5, 2,1,0,0,0,0,0,0,0,0,0,0)},
    {"R4  ", iw('h0D, 1, 6,'hAAAA),  ex(1,1, 6, 3,1,0,0,0,0,0,0,0,0,0,0)},
    {"R4  ", iw('h0E, 1, 7,'hFFFF),  ex(1,1, 7, 4,1,0,0,0,0,0,0,0,0,0,0)},
    {"R5  ", iw('h0F, 0, 8,'hAAAA),  ex(1,1, 8,11,1,0,0,0,0,0,0,0,0,0,0)},
    {"R6  ", iw('h23, 0, 8,'h1008),  ex(1,1, 8, 0,1,1,0,0,0,0,0,0,0,0,1)},
    {"R6  ", iw('h2B, 0, 8,'hFFFC),  ex(1,0, 0, 0,1,0,1,0,0,0,0,0,0,0,1)},
    {"R8  ", iw('h04, 9, 0,'hFFFE),  ex(1,0, 0, 1,0,0,0,1,0,0,0,0,0,0,1)},
    {"R8  ", iw('h05, 9, 3,'h0010),  ex(1,0, 0, 1,0,0,0,0,1,0,0,0,0,0,1)},
    {"R9  ", jw('h02, 'h3FFFFFF),    ex(2,0, 0,15,0,0,0,0,0,1,0,0,0,0,1)},
    {"R9  ", jw('h03, 'h0000123),    ex(2,1,31,15,0,0,0,0,0,1,0,1,0,0,1)},
    {"R12 ", jw('h3F, 'h0000000),    ex(3,0, 0,15,0,0,0,0,0,0,0,0,0,1,1)}
  };

  // bench's own statement of the immediate rule
  function automatic logic [31:0] want_imm(logic [31:0] w);
    logic [5:0] o = w[31:26];
    if (o == 6'h0F) return w[15:0] * 32'h10000;
    if (o >= 6'h0C && o <= 6'h0E) return 32'(w[15:0]);
    return 32'($signed(w[15:0]));
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s insn=%h actual=%h expected=%h", tag, insn, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    insn = w;
    #3;
  endtask

  function automatic bit legal_op(int o);
    return o == 0 || o == 2 || o == 3 || o == 4 || o == 5 || (o >= 8 && o <= 15) || o == 'h23 || o == 'h2B;
  endfunction
  function automatic bit legal_fn(int f);
    return f == 0 || (f >= 2 && f <= 4) || (f >= 6 && f <= 9) || (f >= 'h20 && f <= 'h27) || f == 'h2A || f == 'h2B;
  endfunction

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    insn = '0;
    // settled state on the all-zero word (sll $0,$0,0): register format, writes rd=0
    apply(32'h0);
    check("R2 zero-word", {62'(fmt), reg_we, illegal}, {62'd0, 1'b1, 1'b0});

    // R1 field positions, restated with shifts and masks
    foreach (VEC[k]) begin end
    for (int p = 0; p < 4; p++) begin
      logic [31:0] w;
      w = (p == 0) ? 32'hDEADBEEF : (p == 1) ? 32'h12345678 : (p == 2) ? 32'hFFFFFFFF : 32'h0A5A5A5A;
      apply(w);
      check("R1 fields",
            {opcode, rs_idx, rt_idx, rd_idx, shamt, funct, imm16, target},
            {6'((w >> 26) & 63), 5'((w >> 21) & 31), 5'((w >> 16) & 31), 5'((w >> 11) & 31),
             5'((w >> 6) & 31), 6'(w & 63), 16'(w & 'hFFFF), 26'(w & 'h3FFFFFF)});
    end

    // table walk: control word plus immediate
    for (int k = 0; k < NV; k++) begin
      logic [86:0] v;
      string tg;
      v = VEC[k];
      tg = string'(v[86:55]);
      apply(v[54:23]);
      check(tg, 64'({fmt, reg_we, wr_idx, alu_op, alu_imm, mem_rd, mem_wr, br_eq, br_ne,
                     jmp_abs, jmp_reg, link, shift_var, illegal, imm_sext}), 64'(v[22:0]));
      check("R4 R5 imm_ext", 64'(imm_ext), 64'(want_imm(v[54:23])));
    end

    // linking jumps: jump and write in the same word, rt/rd fields far from 31
    apply(jw('h03, 'h2AAAAAA));
    check("R3 jal dest", {59'd0, reg_we, link, jmp_abs, wr_idx == 5'd31 ? 1'b1 : 1'b0, jmp_reg},
          {59'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0});
    apply(rw(3, 0, 7, 0, 'h09));
    check("R3 jalr dest", {59'd0, reg_we, link, jmp_reg, jmp_abs}, {59'd0, 4'b1110} >> 0);
    check("R3 jalr idx", 64'(wr_idx), 64'd7);

    // every opcode: legality and quiet enables
    for (int o = 0; o < 64; o++) begin
      apply({6'(o), 5'd3, 5'd4, 5'd5, 5'd0, 6'h20});
      check("R12 opcode sweep", {61'd0, illegal, !legal_op(o) && (reg_we | mem_rd | mem_wr | br_eq | br_ne | jmp_abs | jmp_reg | link), fmt == 2'd3},
            {61'd0, !legal_op(o), 1'b0, !legal_op(o)});
    end
    // every funct under the register opcode
    for (int f = 0; f < 64; f++) begin
      apply(rw(3, 4, 5, 0, f));
      check("R12 funct sweep", {62'd0, illegal, !legal_fn(f) && (reg_we | jmp_reg | link | alu_op != 4'd15)},
            {62'd0, !legal_fn(f), 1'b0});
    end

    // R11 operand-B select across immediate opcodes
    for (int o = 8; o <= 15; o++) begin
      apply(iw(o, 1, 2, 'h1234));
      check("R11 alu_imm", 64'(alu_imm), 64'd1);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule